// File: doc/BRIEF.md
# Pipeline Stall Hold Controller

This block sits beside the scheduling stage of an in-order pipeline whose stages run fetch, decode with register read, crossbar read with scheduling, execution, crossbar write and register write. When the scheduler reports a stall, the block turns that single request into hold enables for the stages that must freeze: fetch, decode/register read, and the one-cycle crossbar staging register that sits in front of each execution unit. The scheduler, the execution units, the write crossbar and register write are never frozen.

The block tracks a valid bit for each stage so that it can say what the pipeline is doing. The scheduling stage keeps its instruction while stalled, but the crossbar read select is recomputed on every stalled cycle, because the data source can move from the register file to a bypass path. To tell the crossbar to do this, the block raises a re-run strobe on each stalled cycle that holds a valid instruction. Because the staging registers are held while the execution units keep running, the block feeds the units an empty slot (a bubble) on every stalled cycle. Each held instruction then executes exactly once, on the first cycle after the stall clears.

Top module: `pipe_hold_ctrl`

## Requirements
- R1: While rst_n is low, every hold enable, bubble_insert and xbar_rerun are 0, whatever stall_req is. After reset, sched_valid, every eu_valid bit and wb_valid are 0.
- R2: hold_fetch and hold_decode equal stall_req combinationally, so both rise in the same cycle as the request.
- R3: Every bit of hold_stage equals stall_req combinationally.
- R4: On a stalled cycle the decode and scheduling valid bits keep their values. On an unstalled cycle the scheduling valid takes the decode valid, and the decode valid takes fetch_valid.
- R5: After a clock edge with stall_req high, every eu_valid bit is 0. bubble_insert is 1 exactly when stall_req is high and at least one staging register holds a valid instruction.
- R6: After an unstalled edge, eu_valid[i] equals the staging valid for unit i that stood before that edge. A held instruction therefore executes exactly once, on the first cycle after release.
- R7: xbar_rerun is high exactly when stall_req and sched_valid are both high, and it stays high on each such cycle.
- R8: The write side is never held. wb_valid is 1 two edges after any cycle with a nonzero eu_valid, and 0 otherwise, whatever stall_req does.
- R9: On an unstalled edge, staging register i loads issue_eu[i] only when sched_valid is high. Issue bits are ignored while the scheduling stage is empty, and also while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_req | input | 1 | Stall condition from the scheduler, evaluated every cycle |
| fetch_valid | input | 1 | Fetch presents a valid instruction |
| issue_eu | input | NUM_EU | Per-unit issue from the scheduler, bit i targets unit i |
| hold_fetch | output | 1 | Freeze fetch |
| hold_decode | output | 1 | Freeze decode and register read |
| hold_stage | output | NUM_EU | Freeze the crossbar staging register of each unit |
| bubble_insert | output | 1 | An empty slot is being sent to the units in place of held work |
| xbar_rerun | output | 1 | Recompute the crossbar read select this cycle |
| sched_valid | output | 1 | Scheduling stage holds a valid instruction |
| eu_valid | output | NUM_EU | Per-unit execution valid |
| wb_valid | output | 1 | Register write stage valid |

## Verification
The bench first runs a free-flowing stream with issues spread across the units. This separates correct per-unit routing and the two-cycle write latency from a pipeline that merely passes bits along. Single-cycle and multi-cycle stalls, with work staged, then show whether a held instruction reaches its unit exactly once, rather than never or twice. They also show whether the write side keeps draining during the stall. Stalls with empty staging registers and an empty scheduling stage tell a correct bubble and re-run strobe apart from ones that fire without need. Issue bits driven while the scheduling stage is empty, and while stalled, expose a staging load that ignores its qualifiers.

// File: rtl/pipe_hold_ctrl.sv
module pipe_hold_ctrl #(
  parameter int NUM_EU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_req,
  input  logic              fetch_valid,
  input  logic [NUM_EU-1:0] issue_eu,
  output logic              hold_fetch,
  output logic              hold_decode,
  output logic [NUM_EU-1:0] hold_stage,
  output logic              bubble_insert,
  output logic              xbar_rerun,
  output logic              sched_valid,
  output logic [NUM_EU-1:0] eu_valid,
  output logic              wb_valid
);

  logic              stall;
  logic              dec_v, xr_v, xw_v, rw_v;
  logic [NUM_EU-1:0] stg_v, eu_v;

  // R1: holds are masked in reset
  assign stall         = stall_req & rst_n;
  assign hold_fetch    = stall;
  assign hold_decode   = stall;
  assign hold_stage    = {NUM_EU{stall}};
  assign bubble_insert = stall & (|stg_v);
  assign xbar_rerun    = stall & xr_v;
  assign sched_valid   = xr_v;
  assign eu_valid      = eu_v;
  assign wb_valid      = rw_v;

  // front end: held while stalled (R4)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_v <= 1'b0;
      xr_v  <= 1'b0;
    end else if (!stall) begin
      dec_v <= fetch_valid;
      xr_v  <= dec_v;
    end
  end

  // per-unit staging and execution slots
  for (genvar i = 0; i < NUM_EU; i++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_v[i] <= 1'b0;
        eu_v[i]  <= 1'b0;
      end else begin
        if (!stall) stg_v[i] <= issue_eu[i] & xr_v;  // R9
        eu_v[i] <= stg_v[i] & ~stall;                // R5, R6
      end
    end
  end

  // write side never held (R8)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xw_v <= 1'b0;
      rw_v <= 1'b0;
    end else begin
      xw_v <= |eu_v;
      rw_v <= xw_v;
    end
  end

endmodule

module pipe_hold_ctrl_chk #(
  parameter int NUM_EU = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall_req,
  input logic              hold_fetch,
  input logic              hold_decode,
  input logic [NUM_EU-1:0] hold_stage,
  input logic              xbar_rerun,
  input logic              sched_valid,
  input logic [NUM_EU-1:0] eu_valid,
  input logic              wb_valid
);

  always_comb begin
    if (!rst_n) assert_reset_holds_R1: assert (!hold_fetch && !hold_decode && hold_stage == '0 && !xbar_rerun);
  end

  assert_front_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> (hold_fetch && hold_decode));

  assert_stage_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> (&hold_stage));

  assert_sched_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> $stable(sched_valid));

  assert_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> (eu_valid == '0));

  assert_rerun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && sched_valid) |-> xbar_rerun);

  assert_write_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eu_valid != '0) |=> ##1 wb_valid);

endmodule

bind pipe_hold_ctrl pipe_hold_ctrl_chk #(.NUM_EU(NUM_EU)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_req(stall_req),
  .hold_fetch(hold_fetch), .hold_decode(hold_decode), .hold_stage(hold_stage),
  .xbar_rerun(xbar_rerun), .sched_valid(sched_valid),
  .eu_valid(eu_valid), .wb_valid(wb_valid)
);

// File: tb/sim_pipe_hold_ctrl.sv
`timescale 1ns/1ps
module sim_pipe_hold_ctrl;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall_req = 1'b0;
  logic fetch_valid = 1'b0;
  logic [N-1:0] issue_eu = '0;
  logic hold_fetch, hold_decode, bubble_insert, xbar_rerun, sched_valid, wb_valid;
  logic [N-1:0] hold_stage, eu_valid;

  int checks = 0;
  int errors = 0;

  // model state
  logic m_dec = 0, m_xr = 0, m_xw = 0, m_rw = 0;
  logic [N-1:0] m_stg = '0, m_eu = '0;
  logic [N:0] q[$];

  always #2.5 clk = ~clk;

  pipe_hold_ctrl #(.NUM_EU(N)) u0 (
    .clk(clk), .rst_n(rst_n), .stall_req(stall_req), .fetch_valid(fetch_valid),
    .issue_eu(issue_eu), .hold_fetch(hold_fetch), .hold_decode(hold_decode),
    .hold_stage(hold_stage), .bubble_insert(bubble_insert), .xbar_rerun(xbar_rerun),
    .sched_valid(sched_valid), .eu_valid(eu_valid), .wb_valid(wb_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: registered outputs after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      logic [N:0] e;
      e = q.pop_front();
      chk("R5/R6 eu_valid", {28'd0, eu_valid}, {28'd0, e[N-1:0]});
      chk("R8 wb_valid", {31'd0, wb_valid}, {31'd0, e[N]});
    end
  end

  // driver
  task automatic step(input logic s, input logic fv, input logic [N-1:0] iss);
    logic n_dec, n_xr, n_xw, n_rw;
    logic [N-1:0] n_stg, n_eu;
    @(negedge clk);
    stall_req = s; fetch_valid = fv; issue_eu = iss;
    #0.5;
    chk("R2 hold_fetch", {31'd0, hold_fetch}, {31'd0, s});
    chk("R2 hold_decode", {31'd0, hold_decode}, {31'd0, s});
    chk("R3 hold_stage", {28'd0, hold_stage}, {28'd0, {N{s}}});
    chk("R5 bubble_insert", {31'd0, bubble_insert}, {31'd0, s & (|m_stg)});
    chk("R7 xbar_rerun", {31'd0, xbar_rerun}, {31'd0, s & m_xr});
    chk("R4 sched_valid", {31'd0, sched_valid}, {31'd0, m_xr});
    n_eu = s ? '0 : m_stg;
    n_xw = |m_eu;
    n_rw = m_xw;
    n_dec = m_dec; n_xr = m_xr; n_stg = m_stg;
    if (!s) begin
      n_dec = fv;
      n_xr = m_dec;
      n_stg = iss & {N{m_xr}};  // R9
    end
    m_dec = n_dec; m_xr = n_xr; m_stg = n_stg; m_eu = n_eu; m_xw = n_xw; m_rw = n_rw;
    q.push_back({n_rw, n_eu});
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset masks holds even with stall_req high
    stall_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 hold_fetch in reset", {31'd0, hold_fetch}, 32'd0);
    chk("R1 hold_stage in reset", {28'd0, hold_stage}, 32'd0);
    chk("R1 bubble in reset", {31'd0, bubble_insert}, 32'd0);
    chk("R1 xbar_rerun in reset", {31'd0, xbar_rerun}, 32'd0);
    chk("R1 sched_valid after reset", {31'd0, sched_valid}, 32'd0);
    chk("R1 eu_valid after reset", {28'd0, eu_valid}, 32'd0);
    chk("R1 wb_valid after reset", {31'd0, wb_valid}, 32'd0);
    stall_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R9: issue ignored while scheduling stage is empty
    step(0, 0, 4'b1111);
    step(0, 0, 4'b1111);
    step(0, 0, 4'b0000);
    step(0, 0, 4'b0000);

    // free flow with spread issues (R6, R8)
    step(0, 1, 4'b0000);
    step(0, 1, 4'b0000);
    step(0, 1, 4'b0001);
    step(0, 1, 4'b0010);
    step(0, 1, 4'b0100);
    step(0, 1, 4'b1000);
    step(0, 0, 4'b0011);

    // single-cycle stall with work staged (R5, R6, R4)
    step(0, 1, 4'b0101);
    step(1, 1, 4'b1111);
    step(0, 1, 4'b0000);
    step(0, 1, 4'b1010);

    // multi-cycle stall, issue ignored while stalled (R9, R7, R8)
    step(1, 0, 4'b1111);
    step(1, 0, 4'b0000);
    step(1, 1, 4'b1111);
    step(0, 1, 4'b0000);
    step(0, 0, 4'b0001);

    // drain, then stall with empty staging and empty scheduling stage
    step(0, 0, 4'b0000);
    step(0, 0, 4'b0000);
    step(0, 0, 4'b0000);
    step(1, 0, 4'b0000);
    step(1, 1, 4'b0000);
    step(0, 1, 4'b0000);
    step(0, 1, 4'b1100);

    // back-to-back stall toggling
    step(1, 1, 4'b0011);
    step(0, 1, 4'b0011);
    step(1, 1, 4'b0000);
    step(0, 0, 4'b1001);
    step(1, 0, 4'b0000);
    step(0, 0, 4'b0000);
    repeat (4) step(0, 0, 4'b0000);

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule